// File: doc/BRIEF.md
# Transport Stream Output Pacer

The pacer moves 188-byte transport packets from an upstream byte FIFO onto a byte-wide output port. The rate is set by an internal slot generator. On every slot the block either emits one byte, leaves an idle slot, or fills the line with a null packet when the FIFO has nothing ready at a packet boundary. A packet that has started from the FIFO is always completed. If the FIFO runs dry in the middle of a packet, the output stalls rather than cutting the packet short.

Two 32-bit control words program the block. The first holds the enable, a synchronous clear, gap insertion, null fill, strobe gating, error marking of fill packets, and the choice of slot generator. The second holds the gap length and the rate value. The rate value drives either a 16-bit phase accumulator, where each carry is one byte slot, or a small integer divider. Two pad-timing fields have no function inside the block and are handed straight to the pad logic.

Top module: `ts_pacer`

## Requirements
- R1: The block runs only while ctrl_word bit 0 is 1 and bit 1 is 0. While it is not running, it gives no strobe, no valid and no ready, and it clears its rate, byte and gap counters. After running resumes, the first byte it emits starts a fresh packet with sync set.
- R2: When ctrl_word bit 12 is 1, or bit 11 is 0, slots come from a 16-bit accumulator that adds V = ctrl2_word[31:16] every clock. Each carry out of bit 15 yields one slot, so the block produces about n·V/65536 slots in n clocks, and none when V is 0.
- R3: When ctrl_word bit 12 is 0 and bit 11 is 1, one slot occurs every ctrl2_word[19:16]+1 clocks. Bits 31:20 have no effect in this mode.
- R4: A FIFO packet starts only at a packet boundary, on a byte flagged start-of-packet. Its 188 bytes leave in order, and out_sync is set on its first byte only.
- R5: If the FIFO has no valid byte in the middle of a packet, that slot is idle. The packet is neither truncated nor interleaved with fill bytes.
- R6: When ctrl_word bit 5 is 1 and no start-of-packet byte is valid at a boundary slot, a null packet is emitted. It is 0x47, 0x1F, 0xFF, 0x10 followed by 184 bytes of 0xFF, with sync on the 0x47.
- R7: When ctrl_word bit 7 is 1, byte 1 of every null packet is 0x9F instead of 0x1F.
- R8: When ctrl_word bit 4 is 1, every packet is followed by exactly 2·G+4 idle slots, where G = ctrl2_word[6:0]. When bit 4 is 0, no idle slots are inserted between packets.
- R9: When ctrl_word bit 6 is 1, idle slots give no out_strobe. When it is 0, idle slots still strobe, with out_valid low.
- R10: pad_phase follows ctrl_word bit 3 and pad_trim follows ctrl_word bits 10:8.
- R11: out_valid is high only together with out_strobe, and out_sync only together with out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_word | input | 32 | Main control word |
| ctrl2_word | input | 32 | Gap length [6:0] and rate value [31:16] |
| in_data | input | 8 | FIFO byte |
| in_sop | input | 1 | FIFO byte is a packet's first byte |
| in_valid | input | 1 | FIFO byte available |
| in_ready | output | 1 | Byte taken this cycle when in_valid is high |
| out_strobe | output | 1 | Output byte slot |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Slot carries a byte |
| out_sync | output | 1 | Byte is a packet's first byte |
| pad_phase | output | 1 | Pad clock phase select, passed through |
| pad_trim | output | 3 | Pad delay trim, passed through |

## Verification
Some properties are checked by the assertions on every cycle. These are the pairing of valid with strobe and of sync with valid, and the absence of strobes on gated idle slots. They also cover the cleared state after a stop, silence during a gap, the divider never ticking twice in a row when its divisor is nonzero, and a FIFO packet never leaving the data state early. Other behaviour only the bench scenarios can show. That includes the exact null-packet bytes and the error-marked variant, the gap length for several gap sizes, and the long-run average slot rate in both generator modes. It also includes byte-exact forwarding of FIFO packets under random mid-packet stalls and the switch from data to fill only at boundaries.

// File: rtl/ts_pacer_pkg.sv
package ts_pacer_pkg;

  localparam int PKT_BYTES = 188;
  localparam int IDX_W     = $clog2(PKT_BYTES);
  localparam int GS_W      = 7;
  localparam int GAP_W     = GS_W + 2;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [GAP_W-1:0] gap_t;

  typedef enum logic [1:0] {
    ST_BOUND,
    ST_DATA,
    ST_FILL,
    ST_GAP
  } sched_st_e;

  localparam idx_t LAST_IDX = idx_t'(PKT_BYTES - 1);

  // Idle slots that follow a packet when gap insertion is on.
  function automatic gap_t gap_slots(input logic [GS_W-1:0] gs);
    return gap_t'({gs, 1'b0}) + gap_t'(4);
  endfunction

  // Byte at position idx of a fill packet.
  function automatic logic [7:0] null_byte(input idx_t idx, input logic err);
    logic [7:0] b;
    if (idx == idx_t'(0))      b = 8'h47;
    else if (idx == idx_t'(1)) b = err ? 8'h9F : 8'h1F;
    else if (idx == idx_t'(3)) b = 8'h10;
    else                       b = 8'hFF;
    return b;
  endfunction

endpackage

// File: rtl/ts_rate_gen.sv
module ts_rate_gen #(
  parameter int ACC_W = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             nco_sel,
  input  logic [ACC_W-1:0] rate_val,
  output logic             tick
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   acc_sum;
  logic             acc_carry;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_lim;
  logic             div_wrap;

  assign acc_sum   = {1'b0, acc} + {1'b0, rate_val};
  assign acc_carry = acc_sum[ACC_W];
  assign div_lim   = rate_val[DIV_W-1:0];
  assign div_wrap  = (div_cnt >= div_lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      acc     <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (nco_sel) begin
      acc     <= acc_sum[ACC_W-1:0];
      div_cnt <= '0;
      tick    <= acc_carry;
    end else begin
      acc     <= '0;
      div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
      tick    <= div_wrap;
    end
  end

  assert_idle_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);

  assert_zero_rate_silent_R2: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (nco_sel && rate_val == '0) |=> !tick);

  assert_div_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (!nco_sel && tick && div_lim != '0) |=> !tick);

endmodule

// File: rtl/ts_pkt_sched.sv
module ts_pkt_sched
  import ts_pacer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic            fill_en,
  input  logic            err_mark,
  input  logic            gap_en,
  input  logic            gate_en,
  input  logic [GS_W-1:0] gap_size,
  input  logic [7:0]      in_data,
  input  logic            in_sop,
  input  logic            in_valid,
  output logic            in_ready,
  output logic            out_strobe,
  output logic [7:0]      out_data,
  output logic            out_valid,
  output logic            out_sync
);

  sched_st_e st, st_n;
  idx_t      idx, idx_n;
  gap_t      gap_left, gap_n;

  logic       emit;
  logic [7:0] emit_byte;
  logic       take;
  logic       pkt_start;
  logic       pkt_end;
  logic       slot_idle;

  assign in_ready  = tick && ((st == ST_DATA) || (st == ST_BOUND && in_sop));
  assign slot_idle = tick && !emit;

  always_comb begin
    emit      = 1'b0;
    emit_byte = 8'h00;
    take      = 1'b0;
    pkt_start = 1'b0;
    st_n      = st;
    idx_n     = idx;
    gap_n     = gap_left;
    if (tick) begin
      case (st)
        ST_BOUND: begin
          if (in_valid && in_sop) begin
            emit      = 1'b1;
            emit_byte = in_data;
            take      = 1'b1;
            pkt_start = 1'b1;
            st_n      = ST_DATA;
            idx_n     = idx_t'(1);
          end else if (fill_en) begin
            emit      = 1'b1;
            emit_byte = null_byte(idx_t'(0), err_mark);
            pkt_start = 1'b1;
            st_n      = ST_FILL;
            idx_n     = idx_t'(1);
          end
        end
        ST_DATA: begin
          if (in_valid) begin
            emit      = 1'b1;
            emit_byte = in_data;
            take      = 1'b1;
            idx_n     = idx + 1'b1;
          end
        end
        ST_FILL: begin
          emit      = 1'b1;
          emit_byte = null_byte(idx, err_mark);
          idx_n     = idx + 1'b1;
        end
        default: begin
          gap_n = gap_left - 1'b1;
          if (gap_left <= gap_t'(1)) st_n = ST_BOUND;
        end
      endcase
    end
    pkt_end = emit && (st == ST_DATA || st == ST_FILL) && (idx == LAST_IDX);
    if (pkt_end) begin
      idx_n = '0;
      if (gap_en) begin
        st_n  = ST_GAP;
        gap_n = gap_slots(gap_size);
      end else begin
        st_n = ST_BOUND;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      st         <= ST_BOUND;
      idx        <= '0;
      gap_left   <= '0;
      out_strobe <= 1'b0;
      out_valid  <= 1'b0;
      out_sync   <= 1'b0;
      out_data   <= 8'h00;
    end else begin
      st         <= st_n;
      idx        <= idx_n;
      gap_left   <= gap_n;
      out_strobe <= tick && (emit || !gate_en);
      out_valid  <= emit;
      out_sync   <= pkt_start;
      out_data   <= emit ? emit_byte : 8'h00;
    end
  end

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);

  assert_data_holds_R5: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (st == ST_DATA && !pkt_end) |=> (st == ST_DATA));

  assert_fill_sync_R6: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (pkt_start && !take) |=> (out_sync && out_data == 8'h47));

  assert_gap_silent_R8: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (st == ST_GAP && tick) |=> !out_valid);

  assert_gated_idle_R9: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (slot_idle && gate_en) |=> !out_strobe);

  assert_stop_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!out_valid && !out_strobe && idx == '0 && st == ST_BOUND));

  assert_valid_in_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_strobe);

  assert_sync_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_valid);

endmodule

// File: rtl/ts_pacer.sv
module ts_pacer #(
  parameter int ACC_W = 16,
  parameter int DIV_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ctrl_word,
  input  logic [31:0] ctrl2_word,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_valid,
  output logic        in_ready,
  output logic        out_strobe,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_sync,
  output logic        pad_phase,
  output logic [2:0]  pad_trim
);

  import ts_pacer_pkg::*;

  localparam int RATE_LSB = 16;

  logic             run;
  logic             nco_sel;
  logic             tick;
  logic [ACC_W-1:0] rate_val;
  logic [GS_W-1:0]  gap_size;
  logic             ctrl_unused;

  assign run       = ctrl_word[0] && !ctrl_word[1];
  assign nco_sel   = ctrl_word[12] || !ctrl_word[11];
  assign rate_val  = ctrl2_word[RATE_LSB +: ACC_W];
  assign gap_size  = ctrl2_word[GS_W-1:0];
  assign pad_phase = ctrl_word[3];
  assign pad_trim  = ctrl_word[10:8];

  assign ctrl_unused = ^{ctrl_word[2], ctrl_word[31:13], ctrl2_word[RATE_LSB-1:GS_W]};

  ts_rate_gen #(.ACC_W(ACC_W), .DIV_W(DIV_W)) rate_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .nco_sel  (nco_sel),
    .rate_val (rate_val),
    .tick     (tick)
  );

  ts_pkt_sched sched_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .fill_en    (ctrl_word[5]),
    .err_mark   (ctrl_word[7]),
    .gap_en     (ctrl_word[4]),
    .gate_en    (ctrl_word[6]),
    .gap_size   (gap_size),
    .in_data    (in_data),
    .in_sop     (in_sop),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_strobe (out_strobe),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_sync   (out_sync)
  );

endmodule

// File: tb/ts_pacer_tb_top.sv
module ts_pacer_tb_top;

  localparam logic [31:0] C_EN   = 32'h1;
  localparam logic [31:0] C_RST  = 32'h2;
  localparam logic [31:0] C_GAP  = 32'h10;
  localparam logic [31:0] C_FILL = 32'h20;
  localparam logic [31:0] C_GATE = 32'h40;
  localparam logic [31:0] C_ERR  = 32'h80;
  localparam logic [31:0] C_HS   = 32'h800;
  localparam logic [31:0] C_NCO  = 32'h1000;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] ctrl_word, ctrl2_word;
  logic [7:0] in_data;
  logic in_sop, in_valid, in_ready;
  logic out_strobe, out_valid, out_sync, pad_phase;
  logic [7:0] out_data;
  logic [2:0] pad_trim;

  always #5 clk = ~clk;

  ts_pacer dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ctrl2_word(ctrl2_word),
    .in_data(in_data), .in_sop(in_sop), .in_valid(in_valid), .in_ready(in_ready),
    .out_strobe(out_strobe), .out_data(out_data), .out_valid(out_valid),
    .out_sync(out_sync), .pad_phase(pad_phase), .pad_trim(pad_trim)
  );

  int checks = 0;
  int fails = 0;
  int strobe_cnt = 0;
  int valid_cnt = 0;
  int pair_viol = 0;
  logic [9:0] slot_q[$];
  logic [8:0] src_q[$];
  logic [7:0] exp_q[$];
  bit took = 1'b0;

  // Output monitor: every strobe slot is logged as {valid, sync, data}
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_strobe) begin
        strobe_cnt <= strobe_cnt + 1;
        slot_q.push_back({out_valid, out_sync, out_data});
        if (out_valid) valid_cnt <= valid_cnt + 1;
      end
      if ((out_valid && !out_strobe) || (out_sync && !out_valid))
        pair_viol <= pair_viol + 1;
    end
  end

  // FIFO driver: stalls only on non-first bytes of a packet
  initial begin : drv
    in_valid = 1'b0; in_sop = 1'b0; in_data = 8'h00;
    forever begin
      @(negedge clk);
      if (took && src_q.size() > 0) void'(src_q.pop_front());
      if (src_q.size() > 0) begin
        in_sop   = src_q[0][8];
        in_data  = src_q[0][7:0];
        in_valid = src_q[0][8] || ($urandom_range(3) != 0);
      end else begin
        in_valid = 1'b0; in_sop = 1'b0; in_data = 8'h00;
      end
      #1;
      took = in_valid && in_ready;
    end
  end

  function automatic logic [7:0] exp_null(input int i, input bit err);
    if (i == 0) return 8'h47;
    if (i == 1) return err ? 8'h9F : 8'h1F;
    if (i == 3) return 8'h10;
    return 8'hFF;
  endfunction

  function automatic int nco_expect(input int v, input int n);
    return int'((longint'(n) * longint'(v)) >>> 16);
  endfunction

  function automatic int div_expect(input int d, input int n);
    return n / (d + 1);
  endfunction

  function automatic int abs_diff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // slot_q position of the n-th (0-based) valid byte, or -1
  function automatic int vpos(input int n);
    int c = 0;
    foreach (slot_q[k]) begin
      if (slot_q[k][9]) begin
        if (c == n) return k;
        c++;
      end
    end
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [31:0] c, input logic [31:0] c2);
    @(negedge clk);
    ctrl_word = c;
    ctrl2_word = c2;
  endtask

  task automatic stop_clear();
    set_ctrl(32'h0, 32'h0);
    repeat (3) @(negedge clk);
    src_q.delete();
    slot_q.delete();
    strobe_cnt = 0;
    valid_cnt = 0;
  endtask

  task automatic measure(input int n, output int cnt);
    repeat (4) @(negedge clk);
    strobe_cnt = 0;
    repeat (n) @(negedge clk);
    cnt = strobe_cnt;
  endtask

  task automatic wait_valid(input int n, input int maxc);
    int c = 0;
    while (valid_cnt < n && c < maxc) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic push_pkt();
    for (int i = 0; i < 188; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h47 : 8'($urandom_range(255));
      src_q.push_back({(i == 0), b});
      exp_q.push_back(b);
    end
  endtask

  task automatic cmp_stream(input string req, input int n, input int pkt_sync);
    int bad = 0;
    int syncs = 0;
    int p;
    for (int i = 0; i < n; i++) begin
      p = vpos(i);
      if (p < 0 || slot_q[p][7:0] != exp_q[i]) bad++;
      if (p >= 0 && slot_q[p][8]) begin
        syncs++;
        if (i % 188 != 0) bad++;
      end
    end
    check(bad == 0, req, bad, 0);
    check(syncs == pkt_sync, req, syncs, pkt_sync);
  endtask

  initial begin : watchdog
    #1_800_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int cnt, v, d, p, idles;
    int gs_list[3];
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    ctrl_word = 32'h0;
    ctrl2_word = 32'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!out_strobe && !out_valid && !in_ready, "R1 reset outputs", int'(out_strobe), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(strobe_cnt == 0, "R1 disabled no strobe", strobe_cnt, 0);
    set_ctrl(C_EN | C_RST | C_FILL | C_HS, 32'h0);
    measure(20, cnt);
    check(cnt == 0, "R1 reset bit holds off", cnt, 0);
    stop_clear();

    // R10: pad pass-through
    set_ctrl(32'h0000_0508, 32'h0);
    @(negedge clk);
    check(pad_phase == 1'b1 && pad_trim == 3'd5, "R10 pad fields", {pad_phase, pad_trim}, 4'hD);
    set_ctrl(32'h0000_0600, 32'h0);
    @(negedge clk);
    check(pad_phase == 1'b0 && pad_trim == 3'd6, "R10 pad fields", {pad_phase, pad_trim}, 4'h6);

    // R2: accumulator rate, directed then random
    for (int k = 0; k < 5; k++) begin
      stop_clear();
      v = (k == 0) ? 16'h2000 : (k == 1) ? 0 : $urandom_range(65535, 1);
      set_ctrl(C_EN | C_NCO | ((k == 4) ? C_HS : 32'h0), {16'(v), 16'h0});
      measure(800, cnt);
      check(abs_diff(cnt, nco_expect(v, 800)) <= 2, "R2 accumulator rate", cnt, nco_expect(v, 800));
    end
    stop_clear();
    set_ctrl(C_EN, {16'h1000, 16'h0});
    measure(800, cnt);
    check(abs_diff(cnt, nco_expect(16'h1000, 800)) <= 2, "R2 accumulator when hs clear", cnt, 50);

    // R3: divider rate with noise in ignored bits
    for (int k = 0; k < 4; k++) begin
      stop_clear();
      d = (k == 0) ? 15 : $urandom_range(14);
      v = ($urandom_range(4095) << 4) | d;
      set_ctrl(C_EN | C_HS, {16'(v), 16'h0});
      measure(320, cnt);
      check(abs_diff(cnt, div_expect(d, 320)) <= 2, "R3 divider rate", cnt, div_expect(d, 320));
    end

    // R9: gating
    stop_clear();
    set_ctrl(C_EN | C_GATE | C_HS, 32'h0);
    measure(100, cnt);
    check(cnt == 0, "R9 gated idle no strobe", cnt, 0);
    stop_clear();
    set_ctrl(C_EN | C_HS, 32'h0);
    measure(100, cnt);
    check(abs_diff(cnt, 100) <= 2 && valid_cnt == 0, "R9 ungated idle strobes", cnt, 100);

    // R6: null fill
    stop_clear();
    exp_q.delete();
    for (int i = 0; i < 188; i++) exp_q.push_back(exp_null(i, 1'b0));
    set_ctrl(C_EN | C_FILL | C_HS | C_GATE, 32'h0);
    wait_valid(188, 400);
    cmp_stream("R6 null packet", 188, 1);
    check(slot_q.size() >= 188 && vpos(187) == 187, "R9 gated fill has no idle slot", vpos(187), 187);

    // R7: error-marked fill, two packets
    stop_clear();
    set_ctrl(C_EN | C_FILL | C_ERR | C_HS, 32'h0);
    wait_valid(376, 800);
    p = vpos(1);
    check(p >= 0 && slot_q[p][7:0] == 8'h9F, "R7 marked byte pkt0", (p >= 0) ? int'(slot_q[p][7:0]) : -1, 8'h9F);
    p = vpos(189);
    check(p >= 0 && slot_q[p][7:0] == 8'h9F, "R7 marked byte pkt1", (p >= 0) ? int'(slot_q[p][7:0]) : -1, 8'h9F);
    p = vpos(3);
    check(p >= 0 && slot_q[p][7:0] == 8'h10, "R7 other bytes intact", (p >= 0) ? int'(slot_q[p][7:0]) : -1, 8'h10);

    // R8: gap length for several sizes, and no gap when off
    gs_list[0] = 0; gs_list[1] = 3; gs_list[2] = 127;
    for (int k = 0; k < 4; k++) begin
      int gs;
      gs = (k < 3) ? gs_list[k] : 5;
      stop_clear();
      set_ctrl(C_EN | C_FILL | C_HS | ((k < 3) ? C_GAP : 32'h0), 32'(gs));
      wait_valid(189, 1000);
      idles = vpos(188) - vpos(187) - 1;
      check(idles == ((k < 3) ? gs * 2 + 4 : 0), "R8 gap slots", idles, (k < 3) ? gs * 2 + 4 : 0);
      p = vpos(188);
      check(p >= 0 && slot_q[p][8], "R8 sync after gap", (p >= 0) ? int'(slot_q[p][8]) : -1, 1);
    end

    // R4 / R5: FIFO packets with random mid-packet stalls, fill off
    stop_clear();
    exp_q.delete();
    push_pkt(); push_pkt(); push_pkt();
    set_ctrl(C_EN | C_HS, 32'h0);
    wait_valid(564, 6000);
    cmp_stream("R4 forwarded packets", 564, 3);
    idles = slot_q.size() - valid_cnt;
    check(idles > 0, "R5 stalls seen as idle slots", idles, 1);

    // R5: with fill on, fill only after the last FIFO packet
    stop_clear();
    exp_q.delete();
    push_pkt(); push_pkt();
    for (int i = 0; i < 188; i++) exp_q.push_back(exp_null(i, 1'b1));
    set_ctrl(C_EN | C_HS | C_FILL | C_ERR, 32'h0);
    wait_valid(564, 6000);
    cmp_stream("R5 no fill inside packet", 564, 3);

    // R1: stop mid-packet then restart
    stop_clear();
    set_ctrl(C_EN | C_FILL | C_HS, 32'h0);
    wait_valid(50, 200);
    set_ctrl(32'h0, 32'h0);
    @(negedge clk);
    check(!out_valid && !out_strobe && !in_ready, "R1 stop clears output", int'(out_valid), 0);
    slot_q.delete(); valid_cnt = 0;
    set_ctrl(C_EN | C_FILL | C_HS, 32'h0);
    wait_valid(1, 50);
    p = vpos(0);
    check(p >= 0 && slot_q[p] == {2'b11, 8'h47}, "R1 restart at packet start", (p >= 0) ? int'(slot_q[p]) : -1, 10'h347);
    wait_valid(60, 200);
    set_ctrl(C_EN | C_RST | C_FILL | C_HS, 32'h0);
    repeat (2) @(negedge clk);
    check(!out_valid, "R1 reset bit clears", int'(out_valid), 0);
    slot_q.delete(); valid_cnt = 0;
    set_ctrl(C_EN | C_FILL | C_HS, 32'h0);
    wait_valid(1, 50);
    p = vpos(0);
    check(p >= 0 && slot_q[p] == {2'b11, 8'h47}, "R1 restart after reset bit", (p >= 0) ? int'(slot_q[p]) : -1, 10'h347);

    // R11: valid/sync pairing over the whole run
    check(pair_viol == 0, "R11 valid and sync pairing", pair_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule